// File: doc/BRIEF.md
# Fused-Operation 64-bit Integer ALU

This block is the integer execution core of a 64-bit scalar pipeline. Each cycle it may accept a pair of 64-bit source operands and a 7-bit operation code. It computes the result combinationally and captures it in an output register. The register raises a valid flag one cycle after the request.

Beyond the usual shift, rotate, single-bit, word, add, compare and logic operations, the block executes fused forms. Each fused form stands for a pair of dependent instructions that a decoder has merged into one operation. The fused forms are:

- an add of only the lowest bit of the first operand;
- adds of the first operand shifted right by a fixed distance;
- an add that builds a 32-bit immediate;
- word sums truncated to a bit, a byte or a halfword;
- logic results narrowed to bit 0 or to the low 16 bits.

Any code the block does not recognise returns zero and pulses an illegal flag.

Top module: `int_alu_fused`

## Requirements
- R1: `out_valid_o` equals the `in_valid_i` of the previous cycle. `result_o` loads only when `in_valid_i` is high and holds otherwise. Reset clears all three outputs asynchronously.
- R2: Opcode bits [6:4] pick the family. The shift codes use src2[5:0] as the amount: 0x00 zero-extends src1[31:0] and then shifts left, 0x01 shifts left, 0x05 shifts right logically, 0x07 shifts right arithmetically, 0x09 rotates left and 0x0B rotates right.
- R3: Single-bit codes use bit index src2[5:0]. 0x02 clears that bit of src1, 0x03 sets it and 0x04 inverts it. 0x06 returns that bit of src1 in bit 0, with all other bits zero.
- R4: Word codes work on 32 bits and sign-extend bit 31 of the result. 0x10 adds, 0x12 subtracts, 0x18 shifts left, 0x19 shifts right logically, 0x1A shifts right arithmetically, 0x1C rotates left and 0x1D rotates right. The word shifts use src2[4:0] as the amount.
- R5: Truncated sums of src1+src2: 0x14 gives bit 0 only, 0x15 gives the zero-extended low byte, 0x16 gives the zero-extended low halfword and 0x17 gives the sign-extended low halfword.
- R6: 0x22 returns src2 plus src1[0]. 0x11 returns the same sum with its low 32 bits sign-extended.
- R7: 0x21 returns src1+src2 and 0x20 returns zext(src1[31:0])+src2. Shifted adds return (x<<N)+src2, with x being src1 for 0x29/0x2B/0x2D/0x2F and zext(src1[31:0]) for 0x28/0x2A/0x2C. N is 1 for 0x28/0x29, 2 for 0x2A/0x2B, 3 for 0x2C/0x2D and 4 for 0x2F.
- R8: 0x24 to 0x27 return (src1 >> K) + src2, with K = 29 + opcode[1:0] and the shift logical. 0x23 returns src2 with bits [11:0] cleared, plus src2[11:0] sign-extended.
- R9: 0x30 returns src1-src2. 0x31 and 0x32 return 1 when src1<src2, unsigned and signed respectively, and 0 otherwise. 0x34 and 0x36 return the unsigned and signed maximum. 0x35 and 0x37 return the unsigned and signed minimum.
- R10: Logic codes:
  - 0x40 and, 0x41 src1&~src2, 0x42 or, 0x43 src1|~src2, 0x44 xor, 0x45 xnor.
  - 0x46 sets each byte of src1 to 0xFF if it is non-zero and to 0x00 otherwise.
  - 0x48 sign-extends src1[7:0] and 0x4A sign-extends src1[15:0].
  - 0x49 gives {src2[7:0],src1[7:0]} zero-extended.
  - 0x4B gives {src2[15:0],src1[15:0]} sign-extended from bit 31.
  - 0x52 gives {src2[31:0],src1[31:0]}.
  - 0x51 reverses the byte order of src1.
  - 0x50 reverses the bit order inside each byte of src1.
- R11: Codes 0x60 to 0x67 apply the logic selected by opcode[2:1]: 0 and, 1 or, 2 xor, 3 the byte-saturate of 0x46 on src1. When opcode[0] is 0 the result is bit 0 alone. When it is 1 the result is the zero-extended low 16 bits.
- R12: Every other code gives `result_o` zero and `illegal_o` high in the cycle in which `out_valid_o` reports it. `illegal_o` is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request present this cycle |
| op_i | input | 7 | Operation code |
| src1_i | input | 64 | First operand |
| src2_i | input | 64 | Second operand |
| out_valid_o | output | 1 | Registered result valid |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Registered flag for an unrecognised code |

## Verification
The illegal-code path and a legal result can land in adjacent cycles. In that case the flag must fall at the same edge where a fresh non-zero result appears. The same registers must also keep a stale result steady through idle gaps. The bench streams every one of the 128 opcode values back to back and then runs a long random phase with gaps, so illegal and legal codes alternate at random. On every clock a behavioural model predicts the valid flag, the illegal flag and the result together, and the bench compares all three. Operand patterns include shift amounts whose upper src2 bits are set, sign boundaries and all-ones values.

// File: rtl/alu_fused_pkg.sv
package alu_fused_pkg;
  localparam int XLEN = 64;
  localparam int OP_W = 7;
  localparam int WLEN = 32;

  typedef enum logic [2:0] {
    GRP_SHIFT  = 3'b000,
    GRP_WORD   = 3'b001,
    GRP_ADD    = 3'b010,
    GRP_CMP    = 3'b011,
    GRP_LOGIC  = 3'b100,
    GRP_MISC   = 3'b101,
    GRP_REDUCE = 3'b110,
    GRP_RSVD   = 3'b111
  } op_grp_e;

  localparam logic [OP_W-1:0] OP_SLL_UWZ = 7'h00, OP_SLL  = 7'h01, OP_BCLR = 7'h02,
                              OP_BSET    = 7'h03, OP_BINV = 7'h04, OP_SRL  = 7'h05,
                              OP_BEXT    = 7'h06, OP_SRA  = 7'h07, OP_ROL  = 7'h09,
                              OP_ROR     = 7'h0B;
  localparam logic [OP_W-1:0] OP_ADDW = 7'h10, OP_ODDADDW = 7'h11, OP_SUBW = 7'h12,
                              OP_ADDW_BIT = 7'h14, OP_ADDW_BYTE = 7'h15,
                              OP_ADDW_ZH = 7'h16, OP_ADDW_SH = 7'h17,
                              OP_SLLW = 7'h18, OP_SRLW = 7'h19, OP_SRAW = 7'h1A,
                              OP_ROLW = 7'h1C, OP_RORW = 7'h1D;
  localparam logic [OP_W-1:0] OP_ADD_UWZ = 7'h20, OP_ADD = 7'h21, OP_ODDADD = 7'h22,
                              OP_IMM32ADD = 7'h23, OP_SH4ADD = 7'h2F;
  localparam logic [OP_W-1:0] OP_SUB = 7'h30, OP_SLTU = 7'h31, OP_SLT = 7'h32,
                              OP_MAXU = 7'h34, OP_MINU = 7'h35, OP_MAX = 7'h36,
                              OP_MIN = 7'h37;
  localparam logic [OP_W-1:0] OP_AND = 7'h40, OP_ANDN = 7'h41, OP_OR = 7'h42,
                              OP_ORN = 7'h43, OP_XOR = 7'h44, OP_XNOR = 7'h45,
                              OP_ORCB = 7'h46, OP_SEXTB = 7'h48, OP_PACKH = 7'h49,
                              OP_SEXTH = 7'h4A, OP_PACKW = 7'h4B;
  localparam logic [OP_W-1:0] OP_REVB = 7'h50, OP_REV8 = 7'h51, OP_PACK = 7'h52;

  function automatic logic [XLEN-1:0] sext_w(input logic [WLEN-1:0] v);
    return {{(XLEN-WLEN){v[WLEN-1]}}, v};
  endfunction
endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_fused_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [5:0]      amt_i,
  output logic [XLEN-1:0] res_o,
  output logic            hit_o
);
  localparam int AW = $clog2(XLEN);
  localparam int WW = $clog2(WLEN);

  logic [AW-1:0]   sh_d;
  logic [WW-1:0]   sh_w;
  logic [AW:0]     inv_d;
  logic [WW:0]     inv_w;
  logic [WLEN-1:0] a_lo, rol_w, ror_w, sra_w;
  logic [XLEN-1:0] mask, rol_d, ror_d;

  assign sh_d  = amt_i[AW-1:0];
  assign sh_w  = amt_i[WW-1:0];
  assign inv_d = (AW+1)'(XLEN) - {1'b0, sh_d};
  assign inv_w = (WW+1)'(WLEN) - {1'b0, sh_w};
  assign a_lo  = a_i[WLEN-1:0];
  assign mask  = {{(XLEN-1){1'b0}}, 1'b1} << sh_d;
  assign rol_d = (a_i << sh_d) | (a_i >> inv_d);
  assign ror_d = (a_i >> sh_d) | (a_i << inv_d);
  assign rol_w = (a_lo << sh_w) | (a_lo >> inv_w);
  assign ror_w = (a_lo >> sh_w) | (a_lo << inv_w);
  assign sra_w = $unsigned($signed(a_lo) >>> sh_w);

  always_comb begin
    hit_o = 1'b1;
    res_o = '0;
    case (op_i)
      OP_SLL_UWZ: res_o = {{(XLEN-WLEN){1'b0}}, a_lo} << sh_d;
      OP_SLL:     res_o = a_i << sh_d;
      OP_BCLR:    res_o = a_i & ~mask;
      OP_BSET:    res_o = a_i | mask;
      OP_BINV:    res_o = a_i ^ mask;
      OP_SRL:     res_o = a_i >> sh_d;
      OP_BEXT:    res_o = {{(XLEN-1){1'b0}}, |(a_i & mask)};
      OP_SRA:     res_o = $unsigned($signed(a_i) >>> sh_d);
      OP_ROL:     res_o = rol_d;
      OP_ROR:     res_o = ror_d;
      OP_SLLW:    res_o = sext_w(a_lo << sh_w);
      OP_SRLW:    res_o = sext_w(a_lo >> sh_w);
      OP_SRAW:    res_o = sext_w(sra_w);
      OP_ROLW:    res_o = sext_w(rol_w);
      OP_RORW:    res_o = sext_w(ror_w);
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_fused_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            hit_o
);
  localparam int SRK_BASE = 29;
  localparam int IMM_W    = 12;

  logic [XLEN-1:0] sum, diff, odd, a_zx, sh_base, sh_sum, srk_sum, imm_sum;
  logic [2:0]      sh_n;
  logic [5:0]      srk_amt;
  logic            lt_u, lt_s, is_shadd, is_srk;

  assign sum     = a_i + b_i;
  assign diff    = a_i - b_i;
  assign odd     = b_i + {{(XLEN-1){1'b0}}, a_i[0]};
  assign a_zx    = {{(XLEN-WLEN){1'b0}}, a_i[WLEN-1:0]};
  // low opcode bit picks full src1 or its zero-extended word
  assign sh_base = op_i[0] ? a_i : a_zx;
  assign sh_n    = (op_i == OP_SH4ADD) ? 3'd4 : ({1'b0, op_i[2:1]} + 3'd1);
  assign sh_sum  = (sh_base << sh_n) + b_i;
  assign srk_amt = 6'(SRK_BASE) + {4'b0, op_i[1:0]};
  assign srk_sum = (a_i >> srk_amt) + b_i;
  assign imm_sum = {b_i[XLEN-1:IMM_W], {IMM_W{1'b0}}}
                 + {{(XLEN-IMM_W){b_i[IMM_W-1]}}, b_i[IMM_W-1:0]};
  assign lt_u    = a_i < b_i;
  assign lt_s    = $signed(a_i) < $signed(b_i);
  assign is_shadd = (op_i[6:3] == 4'b0101) && (op_i[2:0] != 3'b110);
  assign is_srk   = (op_i[6:2] == 5'b01001);

  always_comb begin
    hit_o = 1'b1;
    res_o = '0;
    case (op_i)
      OP_ADDW:      res_o = sext_w(sum[WLEN-1:0]);
      OP_ODDADDW:   res_o = sext_w(odd[WLEN-1:0]);
      OP_SUBW:      res_o = sext_w(diff[WLEN-1:0]);
      OP_ADDW_BIT:  res_o = {{(XLEN-1){1'b0}}, sum[0]};
      OP_ADDW_BYTE: res_o = {{(XLEN-8){1'b0}}, sum[7:0]};
      OP_ADDW_ZH:   res_o = {{(XLEN-16){1'b0}}, sum[15:0]};
      OP_ADDW_SH:   res_o = {{(XLEN-16){sum[15]}}, sum[15:0]};
      OP_ADD_UWZ:   res_o = a_zx + b_i;
      OP_ADD:       res_o = sum;
      OP_ODDADD:    res_o = odd;
      OP_IMM32ADD:  res_o = imm_sum;
      OP_SUB:       res_o = diff;
      OP_SLTU:      res_o = {{(XLEN-1){1'b0}}, lt_u};
      OP_SLT:       res_o = {{(XLEN-1){1'b0}}, lt_s};
      OP_MAXU:      res_o = lt_u ? b_i : a_i;
      OP_MINU:      res_o = lt_u ? a_i : b_i;
      OP_MAX:       res_o = lt_s ? b_i : a_i;
      OP_MIN:       res_o = lt_s ? a_i : b_i;
      default: begin
        if (is_shadd)    res_o = sh_sum;
        else if (is_srk) res_o = srk_sum;
        else             hit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_fused_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            hit_o
);
  localparam int NB = XLEN / 8;

  logic [XLEN-1:0] orcb_v, rev8_v, revb_v, red_v;
  logic            red_ok;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign orcb_v[i*8 +: 8] = {8{|a_i[i*8 +: 8]}};
    assign rev8_v[i*8 +: 8] = a_i[(NB-1-i)*8 +: 8];
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign revb_v[i*8+j] = a_i[i*8+7-j];
    end
  end

  always_comb begin
    red_ok = ~op_i[3];
    case (op_i[2:1])
      2'd0:    red_v = a_i & b_i;
      2'd1:    red_v = a_i | b_i;
      2'd2:    red_v = a_i ^ b_i;
      default: red_v = orcb_v;
    endcase
  end

  always_comb begin
    hit_o = 1'b1;
    res_o = '0;
    case (op_i)
      OP_AND:   res_o = a_i & b_i;
      OP_ANDN:  res_o = a_i & ~b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_ORN:   res_o = a_i | ~b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_XNOR:  res_o = ~(a_i ^ b_i);
      OP_ORCB:  res_o = orcb_v;
      OP_SEXTB: res_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
      OP_PACKH: res_o = {{(XLEN-16){1'b0}}, b_i[7:0], a_i[7:0]};
      OP_SEXTH: res_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
      OP_PACKW: res_o = sext_w({b_i[15:0], a_i[15:0]});
      OP_REVB:  res_o = revb_v;
      OP_REV8:  res_o = rev8_v;
      OP_PACK:  res_o = {b_i[WLEN-1:0], a_i[WLEN-1:0]};
      default: begin
        if (op_i[6:4] == GRP_REDUCE && red_ok)
          res_o = op_i[0] ? {{(XLEN-16){1'b0}}, red_v[15:0]}
                          : {{(XLEN-1){1'b0}}, red_v[0]};
        else
          hit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/int_alu_fused.sv
module int_alu_fused
  import alu_fused_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [6:0]      op_i,
  input  logic [63:0]     src1_i,
  input  logic [63:0]     src2_i,
  output logic            out_valid_o,
  output logic [63:0]     result_o,
  output logic            illegal_o
);
  localparam int NU = 3;

  logic [XLEN-1:0] unit_res [NU];
  logic [NU-1:0]   unit_hit;
  logic [XLEN-1:0] comb_res;
  logic            legal;
  logic            valid_q, ill_q;
  logic [XLEN-1:0] res_q;
  op_grp_e         grp;

  assign grp = op_grp_e'(op_i[6:4]);

  alu_shift_unit u_shift (.op_i(op_i), .a_i(src1_i), .amt_i(src2_i[5:0]),
                          .res_o(unit_res[0]), .hit_o(unit_hit[0]));
  alu_arith_unit u_arith (.op_i(op_i), .a_i(src1_i), .b_i(src2_i),
                          .res_o(unit_res[1]), .hit_o(unit_hit[1]));
  alu_logic_unit u_logic (.op_i(op_i), .a_i(src1_i), .b_i(src2_i),
                          .res_o(unit_res[2]), .hit_o(unit_hit[2]));

  // units decode disjoint codes and drive zero on a miss, so OR merges them
  always_comb begin
    comb_res = '0;
    for (int u = 0; u < NU; u++) comb_res |= unit_res[u];
  end
  assign legal = |unit_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid_i;
      ill_q   <= in_valid_i & ~legal;
      if (in_valid_i) res_q <= comb_res;
    end
  end

  assign out_valid_o = valid_q;
  assign illegal_o   = ill_q;
  assign result_o    = res_q;

  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(result_o)));
  assert_illegal_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (out_valid_o && result_o == '0));
  assert_illegal_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !illegal_o);
  assert_no_unit_overlap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(unit_hit));
  assert_reduce_lsb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && grp == GRP_REDUCE && !op_i[0]) |=> result_o[XLEN-1:1] == '0);
  assert_reduce_zexth_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && grp == GRP_REDUCE && op_i[0]) |=> result_o[XLEN-1:16] == '0);
  assert_word_sext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && grp == GRP_WORD && (op_i[3:0] inside {4'h0, 4'h2, 4'h8, 4'h9, 4'hA, 4'hC, 4'hD}))
    |=> result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}});
  assert_trunc_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == OP_ADDW_BYTE) |=> result_o[XLEN-1:8] == '0);
  assert_cmp_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (op_i == OP_SLT || op_i == OP_SLTU)) |=> result_o[XLEN-1:1] == '0);
endmodule

// File: tb/tb_int_alu_fused.sv
module tb_int_alu_fused;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [6:0]  op_i = '0;
  logic [63:0] src1_i = '0, src2_i = '0;
  logic        out_valid_o, illegal_o;
  logic [63:0] result_o;

  int checks = 0, failures = 0;
  logic        exp_valid = 1'b0, exp_ill = 1'b0;
  logic [63:0] exp_res = '0;
  string       exp_tag = "R1";
  logic [63:0] lcg = 64'h2545_F491_4F6C_DD1D;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_fused dut (.clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .op_i(op_i),
                     .src1_i(src1_i), .src2_i(src2_i), .out_valid_o(out_valid_o),
                     .result_o(result_o), .illegal_o(illegal_o));

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] sat_bytes(input logic [63:0] a);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) if (a[k*8 +: 8] != 8'h00) r[k*8 +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [64:0] ref_alu(input logic [6:0] op, input logic [63:0] a, b);
    logic [63:0] r = '0;
    logic [31:0] w = '0;
    logic [31:0] aw = a[31:0];
    logic        ok = 1'b1;
    int s6 = int'(b[5:0]);
    int s5 = int'(b[4:0]);
    case (op)
      7'h00: r = {32'h0, aw} << s6;
      7'h01: r = a << s6;
      7'h02: begin r = a; r[s6] = 1'b0; end
      7'h03: begin r = a; r[s6] = 1'b1; end
      7'h04: begin r = a; r[s6] = ~a[s6]; end
      7'h05: r = a >> s6;
      7'h06: r = {63'd0, a[s6]};
      7'h07: r = 64'($signed(a) >>> s6);
      7'h09: for (int k = 0; k < 64; k++) r[(k+s6)%64] = a[k];
      7'h0B: for (int k = 0; k < 64; k++) r[k] = a[(k+s6)%64];
      7'h10: r = sx32(aw + b[31:0]);
      7'h11: r = sx32(b[31:0] + {31'd0, a[0]});
      7'h12: r = sx32(aw - b[31:0]);
      7'h14: r = {63'd0, a[0] ^ b[0]};
      7'h15: r = (a + b) & 64'hFF;
      7'h16: r = (a + b) & 64'hFFFF;
      7'h17: begin r = a + b; r = {{48{r[15]}}, r[15:0]}; end
      7'h18: r = sx32(aw << s5);
      7'h19: r = sx32(aw >> s5);
      7'h1A: begin w = 32'($signed(aw) >>> s5); r = sx32(w); end
      7'h1C: begin for (int k = 0; k < 32; k++) w[(k+s5)%32] = aw[k]; r = sx32(w); end
      7'h1D: begin for (int k = 0; k < 32; k++) w[k] = aw[(k+s5)%32]; r = sx32(w); end
      7'h20: r = {32'h0, aw} + b;
      7'h21: r = a + b;
      7'h22: r = b + {63'd0, a[0]};
      7'h23: r = (b & ~64'hFFF) + {{52{b[11]}}, b[11:0]};
      7'h24: r = (a >> 29) + b;
      7'h25: r = (a >> 30) + b;
      7'h26: r = (a >> 31) + b;
      7'h27: r = (a >> 32) + b;
      7'h28: r = {32'h0, aw} * 2 + b;
      7'h29: r = a * 2 + b;
      7'h2A: r = {32'h0, aw} * 4 + b;
      7'h2B: r = a * 4 + b;
      7'h2C: r = {32'h0, aw} * 8 + b;
      7'h2D: r = a * 8 + b;
      7'h2F: r = a * 16 + b;
      7'h30: r = a - b;
      7'h31: r = (a < b) ? 64'd1 : 64'd0;
      7'h32: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      7'h34: r = (a > b) ? a : b;
      7'h35: r = (a > b) ? b : a;
      7'h36: r = ($signed(a) > $signed(b)) ? a : b;
      7'h37: r = ($signed(a) > $signed(b)) ? b : a;
      7'h40: r = a & b;
      7'h41: r = a & ~b;
      7'h42: r = a | b;
      7'h43: r = a | ~b;
      7'h44: r = a ^ b;
      7'h45: r = ~(a ^ b);
      7'h46: r = sat_bytes(a);
      7'h48: r = {{56{a[7]}}, a[7:0]};
      7'h49: r = {48'h0, b[7:0], a[7:0]};
      7'h4A: r = {{48{a[15]}}, a[15:0]};
      7'h4B: r = sx32({b[15:0], a[15:0]});
      7'h50: for (int k = 0; k < 64; k++) r[k] = a[(k/8)*8 + 7 - (k%8)];
      7'h51: for (int k = 0; k < 8; k++) r[k*8 +: 8] = a[(7-k)*8 +: 8];
      7'h52: r = {b[31:0], aw};
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
        case (op[2:1])
          2'd0: r = a & b;
          2'd1: r = a | b;
          2'd2: r = a ^ b;
          default: r = sat_bytes(a);
        endcase
        r = op[0] ? (r & 64'hFFFF) : (r & 64'd1);
      end
      default: ok = 1'b0;
    endcase
    return {ok, r};
  endfunction

  function automatic string tag_of(input logic [6:0] op, input logic ok);
    if (!ok) return "R12";
    case (op[6:4])
      3'b000: return (op inside {7'h02, 7'h03, 7'h04, 7'h06}) ? "R3" : "R2";
      3'b001: return (op inside {7'h14, 7'h15, 7'h16, 7'h17}) ? "R5" : (op == 7'h11) ? "R6" : "R4";
      3'b010: return (op == 7'h22) ? "R6" : (op inside {[7'h23:7'h27]}) ? "R8" : "R7";
      3'b011: return "R9";
      3'b110: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic check_now();
    checks++;
    if (out_valid_o !== exp_valid || illegal_o !== exp_ill || result_o !== exp_res) begin
      failures++;
      $display("FAIL %s: valid=%b ill=%b res=%h expected valid=%b ill=%b res=%h",
               exp_tag, out_valid_o, illegal_o, result_o, exp_valid, exp_ill, exp_res);
    end
  endtask

  task automatic step(input logic v, input logic [6:0] op, input logic [63:0] a, b);
    logic [64:0] m;
    @(negedge clk);
    check_now();
    in_valid_i = v; op_i = op; src1_i = a; src2_i = b;
    if (v) begin
      m = ref_alu(op, a, b);
      exp_valid = 1'b1;
      exp_ill = ~m[64];
      exp_res = m[64] ? m[63:0] : 64'd0;
      exp_tag = tag_of(op, m[64]);
    end else begin
      exp_valid = 1'b0;
      exp_ill = 1'b0;
      exp_tag = "R1";
    end
  endtask

  function automatic logic [63:0] next_rand();
    lcg = lcg * 64'h5851_F42D_4C95_7F2D + 64'h1405_7B7E_F767_814F;
    return lcg;
  endfunction

  logic [63:0] pat_a [6] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001,
                             64'h0000_0000_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h0F00_8001_7FFF_8000};
  logic [63:0] pat_b [6] = '{64'h0, 64'h0000_0000_0000_003F, 64'hFFFF_FFFF_FFFF_FFC3,
                             64'h0000_0000_0000_0020, 64'hFFFF_FFFF_8000_0801, 64'h7FFF_FFFF_FFFF_F81F};

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state seen at the first step's check
    for (int op = 0; op < 128; op++)
      for (int p = 0; p < 6; p++)
        step(1'b1, 7'(op), pat_a[p], pat_b[p]);
    // R1/R12: random codes, operands and idle gaps
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] r0 = next_rand();
      logic [63:0] r1 = next_rand();
      logic [63:0] r2 = next_rand();
      step(r0[60:59] != 2'b00, r0[6:0], r1, r2);
    end
    step(1'b0, 7'h00, 64'h0, 64'h0);
    step(1'b0, 7'h21, 64'h5, 64'h6);
    // R1: asynchronous reset mid-run
    @(negedge clk);
    check_now();
    in_valid_i = 1'b1; op_i = 7'h21; src1_i = 64'd7; src2_i = 64'd8;
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    exp_valid = 1'b0; exp_ill = 1'b0; exp_res = '0; exp_tag = "R1";
    #1;
    check_now();
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, 7'h00, 64'h0, 64'h0);
    step(1'b0, 7'h00, 64'h0, 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R1: watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule